// File: doc/BRIEF.md
# Frame-Synchronized Double-Buffered Register Bank

This block is a display timing unit. It steps through a programmable raster, counting pixel positions along each line and lines within each frame. In the vertical blanking region it raises three global sync pulses: a fetch-begin pulse, a commit pulse and a ready pulse. Each pulse sits on a programmable line and lasts exactly one cycle, the first cycle of that line. A configuration check rejects any sync line that falls outside blanking or that shares its line with another pulse. A rejected pulse is not produced, and an error flag is raised.

The block also holds a bank of configuration words, such as a surface base address, in two copies. The host writes the pending copy at any time. The whole pending bank is copied into the active bank at once, and only on the commit pulse. Between two commits the pending copy behaves as a mailbox: only the last value written to each word survives. A dirty flag records that a write happened since the last commit. When a commit takes dirty data, a one-cycle flip-done event is produced. The rest of the system treats this event as its frame flip or vsync notification.

Top module: `frame_sync_regbank`

## Requirements
- R1: `hcnt` counts 0 up to `cfg_htotal`-1 and then wraps to 0. `vcnt` advances by one each time `hcnt` wraps, and wraps to 0 after line `cfg_vtotal`-1.
- R2: When its line is valid, each sync pulse is high for exactly one cycle per frame: the cycle in which `hcnt`=0 and `vcnt` equals that pulse's line. The begin pulse uses `cfg_line_begin`, the commit pulse uses `cfg_line_commit` and the ready pulse uses `cfg_line_ready`.
- R3: A sync line is valid only if it lies in blanking, that is `cfg_vact_end` <= line < `cfg_vtotal`. A pulse whose line lies outside that range never fires, and `cfg_err` is 1 while the condition holds.
- R4: When two sync lines are equal, neither of those two pulses fires, and `cfg_err` is 1. The third pulse is unaffected.
- R5: No two of the three sync pulses are ever high in the same cycle.
- R6: A host write (`wr_en`=1, word index `wr_addr`, value `wr_data`) changes only the pending copy. `act_data` does not change in any cycle that does not follow a commit pulse.
- R7: On a commit pulse every active word takes its pending value. When several writes to one word occur between commits, the last one becomes active. Word i appears on `act_data[i*DW +: DW]`.
- R8: `flip_done` is high for exactly the one cycle after a commit pulse, and only if `pend_dirty` was 1 during that commit cycle. `pend_dirty` is set by any write and cleared by a commit.
- R9: A write in the same cycle as a commit pulse is not part of that commit. It stays pending, `pend_dirty` stays 1, and the value becomes active at the next commit.
- R10: During reset `hcnt` and `vcnt` are 0, every active word equals `RST_VAL`, and both `flip_done` and `pend_dirty` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_htotal | input | HW | Cycles per line |
| cfg_vtotal | input | VW | Lines per frame |
| cfg_vact_end | input | VW | First blanking line |
| cfg_line_begin | input | VW | Line of the fetch-begin pulse |
| cfg_line_commit | input | VW | Line of the commit pulse |
| cfg_line_ready | input | VW | Line of the ready pulse |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | AW | Word index of the write |
| wr_data | input | DW | Value written to the pending copy |
| hcnt | output | HW | Pixel counter |
| vcnt | output | VW | Line counter |
| gs_begin | output | 1 | Fetch-begin pulse |
| gs_commit | output | 1 | Commit pulse |
| gs_ready | output | 1 | Ready pulse |
| cfg_err | output | 1 | Sync line placement error |
| flip_done | output | 1 | Dirty data reached the active bank |
| pend_dirty | output | 1 | Pending copy written since the last commit |
| act_data | output | NREGS*DW | Active bank, word i at bits i*DW +: DW |

## Verification
The two functions that can fall in the same cycle are a host write and the commit that copies the pending bank. The bench first makes the bank dirty. It then drives a new value exactly on the cycle in which the commit pulse is high. The test is judged correct on three points. The commit must deliver the older value and raise `flip_done`. The dirty flag must stay set. The newer value must appear only at the following commit, together with a second `flip_done`.

// File: rtl/frame_sync_regbank.sv
module frame_sync_regbank #(
  parameter int HW = 12,
  parameter int VW = 12,
  parameter int NREGS = 4,
  parameter int DW = 32,
  parameter logic [DW-1:0] RST_VAL = '0,
  localparam int AW = (NREGS > 1) ? $clog2(NREGS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HW-1:0]     cfg_htotal,
  input  logic [VW-1:0]     cfg_vtotal,
  input  logic [VW-1:0]     cfg_vact_end,
  input  logic [VW-1:0]     cfg_line_begin,
  input  logic [VW-1:0]     cfg_line_commit,
  input  logic [VW-1:0]     cfg_line_ready,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  output logic [HW-1:0]     hcnt,
  output logic [VW-1:0]     vcnt,
  output logic              gs_begin,
  output logic              gs_commit,
  output logic              gs_ready,
  output logic              cfg_err,
  output logic              flip_done,
  output logic              pend_dirty,
  output logic [NREGS*DW-1:0] act_data
);

  logic [DW-1:0] pend_q [NREGS];
  logic [DW-1:0] act_q  [NREGS];

  wire h_last = (hcnt >= cfg_htotal - 1'b1);
  wire v_last = (vcnt >= cfg_vtotal - 1'b1);
  wire line_start = (hcnt == '0);

  wire blank_b = (cfg_line_begin  >= cfg_vact_end) && (cfg_line_begin  < cfg_vtotal);
  wire blank_c = (cfg_line_commit >= cfg_vact_end) && (cfg_line_commit < cfg_vtotal);
  wire blank_r = (cfg_line_ready  >= cfg_vact_end) && (cfg_line_ready  < cfg_vtotal);

  wire ok_b = blank_b && (cfg_line_begin  != cfg_line_commit) && (cfg_line_begin != cfg_line_ready);
  wire ok_c = blank_c && (cfg_line_commit != cfg_line_begin)  && (cfg_line_commit != cfg_line_ready);
  wire ok_r = blank_r && (cfg_line_ready  != cfg_line_begin)  && (cfg_line_ready != cfg_line_commit);

  assign cfg_err   = !(ok_b && ok_c && ok_r);
  assign gs_begin  = line_start && (vcnt == cfg_line_begin)  && ok_b;
  assign gs_commit = line_start && (vcnt == cfg_line_commit) && ok_c;
  assign gs_ready  = line_start && (vcnt == cfg_line_ready)  && ok_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hcnt <= '0;
      vcnt <= '0;
    end else if (h_last) begin
      hcnt <= '0;
      vcnt <= v_last ? '0 : vcnt + 1'b1;
    end else begin
      hcnt <= hcnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_dirty <= 1'b0;
      flip_done  <= 1'b0;
    end else begin
      flip_done  <= gs_commit && pend_dirty;
      pend_dirty <= wr_en || (pend_dirty && !gs_commit);
    end
  end

  for (genvar i = 0; i < NREGS; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend_q[i] <= RST_VAL;
        act_q[i]  <= RST_VAL;
      end else begin
        if (wr_en && (wr_addr == AW'(i))) pend_q[i] <= wr_data;
        if (gs_commit) act_q[i] <= pend_q[i];
      end
    end
    assign act_data[i*DW +: DW] = act_q[i];
  end

endmodule

// File: rtl/frame_sync_regbank_chk.sv
module frame_sync_regbank_chk #(
  parameter int HW = 12,
  parameter int VW = 12,
  parameter int NREGS = 4,
  parameter int DW = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic [VW-1:0]       cfg_vact_end,
  input logic [HW-1:0]       hcnt,
  input logic [VW-1:0]       vcnt,
  input logic                gs_begin,
  input logic                gs_commit,
  input logic                gs_ready,
  input logic                flip_done,
  input logic [NREGS*DW-1:0] act_data
);
  // R5
  sync_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({gs_begin, gs_commit, gs_ready}));
  // R2
  pulse_line_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gs_begin || gs_commit || gs_ready) |-> (hcnt == '0));
  // R3
  pulse_in_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gs_begin || gs_commit || gs_ready) |-> (vcnt >= cfg_vact_end));
  // R6
  active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gs_commit |=> $stable(act_data));
  // R8
  flip_after_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gs_commit |=> !flip_done);
  // R8
  flip_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flip_done |=> !flip_done);
endmodule

bind frame_sync_regbank frame_sync_regbank_chk #(
  .HW(HW), .VW(VW), .NREGS(NREGS), .DW(DW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_vact_end(cfg_vact_end), .hcnt(hcnt), .vcnt(vcnt),
  .gs_begin(gs_begin), .gs_commit(gs_commit), .gs_ready(gs_ready),
  .flip_done(flip_done), .act_data(act_data)
);

// File: tb/test_frame_sync_regbank.sv
`timescale 1ns/1ps
module test_frame_sync_regbank;
  localparam int HW = 12, VW = 12, NREGS = 4, DW = 32;
  localparam int H = 8, V = 10, VA = 6;
  localparam logic [DW-1:0] RV = 32'hA5A5_0000;

  logic clk = 0, rst_n = 0;
  logic [VW-1:0] lb = 6, lc = 7, lr = 8;
  logic wr_en = 0;
  logic [1:0] wr_addr = 0;
  logic [DW-1:0] wr_data = 0;
  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;
  logic gs_begin, gs_commit, gs_ready, cfg_err, flip_done, pend_dirty;
  logic [NREGS*DW-1:0] act_data;
  int checks = 0, fails = 0;
  int cyc = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

  frame_sync_regbank #(.HW(HW), .VW(VW), .NREGS(NREGS), .DW(DW), .RST_VAL(RV)) i_frame_sync_regbank (
    .clk(clk), .rst_n(rst_n), .cfg_htotal(HW'(H)), .cfg_vtotal(VW'(V)), .cfg_vact_end(VW'(VA)),
    .cfg_line_begin(lb), .cfg_line_commit(lc), .cfg_line_ready(lr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .hcnt(hcnt), .vcnt(vcnt), .gs_begin(gs_begin), .gs_commit(gs_commit), .gs_ready(gs_ready),
    .cfg_err(cfg_err), .flip_done(flip_done), .pend_dirty(pend_dirty), .act_data(act_data));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] word(input int i);
    return act_data[i*DW +: DW];
  endfunction

  task automatic wr(input int a, input logic [DW-1:0] d);
    wr_en = 1; wr_addr = 2'(a); wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic wait_commit;
    while (!gs_commit) @(negedge clk);
  endtask

  task automatic wait_line(input int l);
    while (!(vcnt == VW'(l) && hcnt == 0)) @(negedge clk);
  endtask

  // Runs one frame and compares every pulse to the raster model.
  task automatic check_frame(input string tag, input bit eb, input bit ec, input bit er);
    int mb = 0, mc = 0, mr = 0, nb = 0, nc = 0, nr = 0;
    for (int k = 0; k < H * V; k++) begin
      @(negedge clk);
      if (gs_begin  !== (eb && cyc % H == 0 && (cyc / H) % V == lb)) mb++;
      if (gs_commit !== (ec && cyc % H == 0 && (cyc / H) % V == lc)) mc++;
      if (gs_ready  !== (er && cyc % H == 0 && (cyc / H) % V == lr)) mr++;
      nb += gs_begin; nc += gs_commit; nr += gs_ready;
    end
    chk({tag, " begin pulse mismatches"}, mb, 0);
    chk({tag, " commit pulse mismatches"}, mc, 0);
    chk({tag, " ready pulse mismatches"}, mr, 0);
    chk({tag, " pulse count"}, nb + nc + nr, eb + ec + er);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R10 hcnt", hcnt, 0);
    chk("R10 vcnt", vcnt, 0);
    chk("R10 active word3", word(3), RV);
    chk("R10 flip_done", flip_done, 0);
    chk("R10 pend_dirty", pend_dirty, 0);
    rst_n = 1;
  endtask

  task automatic t_raster;
    int bad = 0;
    for (int k = 0; k < 2 * H * V + 3; k++) begin
      @(negedge clk);
      if (hcnt != cyc % H || vcnt != (cyc / H) % V) bad++;
    end
    chk("R1 raster position mismatches", bad, 0);
    chk("R3 cfg_err clear on valid lines", cfg_err, 0);
    check_frame("R2", 1, 1, 1);
  endtask

  task automatic t_mailbox;
    wait_line(1);
    wr(0, 32'h1111); wr(0, 32'h2222); wr(2, 32'h7777); wr(0, 32'h3333);
    chk("R8 dirty after writes", pend_dirty, 1);
    chk("R6 active unchanged before commit", word(0), RV);
    wait_commit;
    chk("R6 active still unchanged in commit cycle", word(0), RV);
    @(negedge clk);
    chk("R7 last write wins", word(0), 32'h3333);
    chk("R7 second word copied", word(2), 32'h7777);
    chk("R8 flip_done after dirty commit", flip_done, 1);
    chk("R8 dirty cleared", pend_dirty, 0);
    @(negedge clk);
    chk("R8 flip_done one cycle", flip_done, 0);
  endtask

  task automatic t_clean_commit;
    int seen = 0;
    wait_line(2);
    wait_commit;
    for (int k = 0; k < 3; k++) begin @(negedge clk); seen += flip_done; end
    chk("R8 no flip_done on clean commit", seen, 0);
    chk("R7 active kept on clean commit", word(0), 32'h3333);
  endtask

  task automatic t_same_cycle;
    wait_line(1);
    wr(1, 32'hBEEF);
    wait_commit;
    wr(1, 32'hCAFE);
    chk("R9 commit takes older value", word(1), 32'hBEEF);
    chk("R9 flip_done for older value", flip_done, 1);
    chk("R9 dirty kept by colliding write", pend_dirty, 1);
    wait_line(2);
    wait_commit;
    @(negedge clk);
    chk("R9 colliding value at next commit", word(1), 32'hCAFE);
    chk("R9 flip_done at next commit", flip_done, 1);
  endtask

  task automatic t_bad_lines;
    wait_line(1);
    lc = 3;
    @(negedge clk);
    chk("R3 cfg_err with commit in active", cfg_err, 1);
    wr(3, 32'hDEAD);
    wait_line(0);
    check_frame("R3", 1, 0, 1);
    chk("R3 suppressed commit leaves active", word(3), RV);
    lc = 7; lr = 6;
    @(negedge clk);
    chk("R4 cfg_err on shared line", cfg_err, 1);
    wait_line(0);
    check_frame("R4", 0, 1, 0);
    chk("R4 commit still delivers", word(3), 32'hDEAD);
    lr = 10;
    @(negedge clk);
    chk("R3 cfg_err line past vtotal", cfg_err, 1);
    wait_line(0);
    check_frame("R3 range", 1, 1, 0);
    lr = 8;
    @(negedge clk);
    chk("R3 cfg_err cleared", cfg_err, 0);
    wait_line(0);
    check_frame("R5 restored", 1, 1, 1);
  endtask

  initial begin
    #1_000_000;
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    t_raster;
    t_mailbox;
    t_clean_commit;
    t_same_cycle;
    t_bad_lines;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule